// File: doc/BRIEF.md
# Dot-Matrix Row Scan Serializer

This block keeps a 128-column by 32-row monochrome scanning display refreshed from a frame buffer held in an external RAM. Each row of the image is 16 bytes. The block reads those bytes one at a time, only in cycles where the RAM arbiter gives it an access slot. It turns each byte into a serial bit stream, most significant bit first, with one data-clock strobe per bit. Once all 128 bits of a row have been sent, it pulses a row-latch strobe. The display latches the completed row on that strobe and shows it while the next row is shifted in behind it.

The frame-buffer page to scan comes from a page-select input, which is driven by a register the CPU writes. The block samples this input only when a new frame begins, so the displayed image never mixes two pages. It also gives the CPU two kinds of timing information. A frame-start flag accompanies the latch of the first row. A sticky interrupt is raised when the row just latched equals a CPU-programmed row number, and the row now on the display can be read at all times.

Top module: `dotscan_top`

## Requirements
- R1: The read address is `{page, row, byte}`: page in the top 4 bits, row in the middle 5 bits, and byte index in the low 4 bits. Bytes 0..15 of a row are read in ascending order. Rows advance 0..31 and then wrap to 0.
- R2: `ram_rd` is high only in cycles where `slot_en` is high. The block takes `ram_rdata` in the cycle after the read.
- R3: Each byte goes out MSB first as 8 consecutive cycles with `ser_clk` high, giving 128 serial bits per row. `ser_data` is 0 whenever `ser_clk` is low.
- R4: `row_latch` is a one-cycle pulse. It is issued in the cycle right after the 128th bit of a row.
- R5: From the cycle after `row_latch`, `scan_row` holds the index of the row just latched.
- R6: `frame_start` is high together with `row_latch` exactly when the row being latched is row 0.
- R7: `page_sel` is sampled only when fetching of row 0 begins, after reset or after the latch of row 31. A change during a frame first affects the next frame.
- R8: `irq` goes high in the cycle after `row_latch` for a row equal to `irq_row`. It stays high until it is acknowledged.
- R9: An `irq_ack` pulse clears `irq` in the following cycle. If a match happens in the same cycle as the acknowledge, the set wins.
- R10: When `slot_en` is held high, one row takes 161 cycles (16 bytes × 10 cycles, plus the latch cycle).
- R11: During reset, `ser_clk`, `ram_rd`, `row_latch`, `irq` and `scan_row` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_en | input | 1 | RAM access slot granted to this block in this cycle |
| page_sel | input | 4 | Frame-buffer page to scan, from the CPU register |
| irq_row | input | 5 | Row number that raises the interrupt |
| irq_ack | input | 1 | Clears the interrupt flag |
| ram_rd | output | 1 | RAM read request |
| ram_addr | output | 13 | RAM read address `{page,row,byte}` |
| ram_rdata | input | 8 | RAM read data, valid the cycle after `ram_rd` |
| ser_clk | output | 1 | Serial data clock strobe, one per bit |
| ser_data | output | 1 | Serial column data |
| row_latch | output | 1 | Row latch / start strobe to the display |
| frame_start | output | 1 | High with `row_latch` for row 0 |
| scan_row | output | 5 | Row currently shown on the display |
| irq | output | 1 | Sticky row-match interrupt |

## Verification
When a read is issued in cycle t, that byte's bits appear on `ser_clk`/`ser_data` in cycles t+2 through t+9. The latch strobe arrives one cycle after the last bit of a row. `scan_row` and `irq` take their new values one cycle after the strobe, and an acknowledge takes effect one cycle later. The bench samples on the falling clock edge. It compares the serial stream against a queue of expected bits and rows, so slot gaps change only timing and not content. Results due a cycle after the strobe are checked at the next falling edge through a pending flag. The 161-cycle row period is measured directly while slots are always granted.

// File: rtl/dotscan_pkg.sv
package dotscan_pkg;

  typedef enum logic [2:0] {
    ST_INIT  = 3'd0,
    ST_FETCH = 3'd1,
    ST_WAIT  = 3'd2,
    ST_SHIFT = 3'd3,
    ST_LATCH = 3'd4
  } scan_state_e;

  // True when idx is the final position of a count-long run
  function automatic logic at_last(int unsigned idx, int unsigned count);
    return idx == count - 1;
  endfunction

  // Cycles needed for one row when every slot is granted
  function automatic int unsigned row_cycles(int unsigned bytes, int unsigned bits);
    return bytes * (bits + 2) + 1;
  endfunction

endpackage

// File: rtl/dotscan_seq.sv
module dotscan_seq
  import dotscan_pkg::*;
#(
  parameter int ROWS          = 32,
  parameter int BYTES_PER_ROW = 16,
  parameter int BYTE_W        = 8,
  parameter int ROW_W         = 5,
  parameter int BIDX_W        = 4,
  parameter int BIT_W         = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_en,
  output logic [ROW_W-1:0]  row_q,
  output logic [BIDX_W-1:0] byte_q,
  output logic              fetch_go,
  output logic              load_evt,
  output logic              shift_evt,
  output logic              latch_evt,
  output logic              frame_load
);

  scan_state_e            state_q;
  logic [BIT_W-1:0]       bit_q;
  logic                   byte_done;
  logic                   row_done;

  function automatic logic [ROW_W-1:0] next_row(logic [ROW_W-1:0] r);
    if (at_last(int'(r), ROWS)) return '0;
    return r + 1'b1;
  endfunction

  assign fetch_go   = (state_q == ST_FETCH) && slot_en;
  assign load_evt   = (state_q == ST_WAIT);
  assign shift_evt  = (state_q == ST_SHIFT);
  assign latch_evt  = (state_q == ST_LATCH);
  assign byte_done  = shift_evt && at_last(int'(bit_q), BYTE_W);
  assign row_done   = byte_done && at_last(int'(byte_q), BYTES_PER_ROW);
  assign frame_load = (state_q == ST_INIT) ||
                      (latch_evt && at_last(int'(row_q), ROWS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_INIT;
      row_q   <= '0;
      byte_q  <= '0;
      bit_q   <= '0;
    end else begin
      case (state_q)
        ST_INIT:  state_q <= ST_FETCH;
        ST_FETCH: if (slot_en) state_q <= ST_WAIT;
        ST_WAIT: begin
          state_q <= ST_SHIFT;
          bit_q   <= '0;
        end
        ST_SHIFT: begin
          bit_q <= bit_q + 1'b1;
          if (row_done) begin
            state_q <= ST_LATCH;
          end else if (byte_done) begin
            state_q <= ST_FETCH;
            byte_q  <= byte_q + 1'b1;
          end
        end
        ST_LATCH: begin
          state_q <= ST_FETCH;
          byte_q  <= '0;
          row_q   <= next_row(row_q);
        end
        default: state_q <= ST_INIT;
      endcase
    end
  end

endmodule

// File: rtl/dotscan_piso.sv
module dotscan_piso #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic [BYTE_W-1:0] din,
  output logic              sout
);

  logic [BYTE_W-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh_q <= '0;
    else if (load)  sh_q <= din;
    else if (shift) sh_q <= {sh_q[BYTE_W-2:0], 1'b0};
  end

  assign sout = sh_q[BYTE_W-1];

endmodule

// File: rtl/dotscan_page.sv
module dotscan_page #(
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_load,
  input  logic [PAGE_W-1:0] page_sel,
  output logic [PAGE_W-1:0] act_page
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          act_page <= '0;
    else if (frame_load) act_page <= page_sel;
  end

endmodule

// File: rtl/dotscan_rowirq.sv
module dotscan_rowirq #(
  parameter int ROW_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             latch_evt,
  input  logic [ROW_W-1:0] row,
  input  logic [ROW_W-1:0] irq_row,
  input  logic             irq_ack,
  output logic             set_evt,
  output logic             frame_start,
  output logic [ROW_W-1:0] scan_row,
  output logic             irq
);

  assign set_evt     = latch_evt && (row == irq_row);
  assign frame_start = latch_evt && (row == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scan_row <= '0;
      irq      <= 1'b0;
    end else begin
      if (latch_evt) scan_row <= row;
      if (set_evt)      irq <= 1'b1;
      else if (irq_ack) irq <= 1'b0;
    end
  end

endmodule

// File: rtl/dotscan_top.sv
module dotscan_top #(
  parameter int COLS   = 128,
  parameter int ROWS   = 32,
  parameter int PAGES  = 16,
  parameter int BYTE_W = 8,
  localparam int BYTES_PER_ROW = COLS / BYTE_W,
  localparam int ROW_W  = $clog2(ROWS),
  localparam int PAGE_W = $clog2(PAGES),
  localparam int BIDX_W = $clog2(BYTES_PER_ROW),
  localparam int BIT_W  = $clog2(BYTE_W),
  localparam int ADDR_W = PAGE_W + ROW_W + BIDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_en,
  input  logic [PAGE_W-1:0] page_sel,
  input  logic [ROW_W-1:0]  irq_row,
  input  logic              irq_ack,
  output logic              ram_rd,
  output logic [ADDR_W-1:0] ram_addr,
  input  logic [BYTE_W-1:0] ram_rdata,
  output logic              ser_clk,
  output logic              ser_data,
  output logic              row_latch,
  output logic              frame_start,
  output logic [ROW_W-1:0]  scan_row,
  output logic              irq
);

  logic [ROW_W-1:0]  row_q;
  logic [BIDX_W-1:0] byte_q;
  logic [PAGE_W-1:0] act_page;
  logic              fetch_go;
  logic              load_evt;
  logic              shift_evt;
  logic              latch_evt;
  logic              frame_load;
  logic              set_evt;
  logic              sh_out;

  dotscan_seq #(
    .ROWS(ROWS), .BYTES_PER_ROW(BYTES_PER_ROW), .BYTE_W(BYTE_W),
    .ROW_W(ROW_W), .BIDX_W(BIDX_W), .BIT_W(BIT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .slot_en(slot_en),
    .row_q(row_q), .byte_q(byte_q),
    .fetch_go(fetch_go), .load_evt(load_evt), .shift_evt(shift_evt),
    .latch_evt(latch_evt), .frame_load(frame_load)
  );

  dotscan_page #(.PAGE_W(PAGE_W)) u_page (
    .clk(clk), .rst_n(rst_n), .frame_load(frame_load),
    .page_sel(page_sel), .act_page(act_page)
  );

  dotscan_piso #(.BYTE_W(BYTE_W)) u_piso (
    .clk(clk), .rst_n(rst_n), .load(load_evt), .shift(shift_evt),
    .din(ram_rdata), .sout(sh_out)
  );

  dotscan_rowirq #(.ROW_W(ROW_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .latch_evt(latch_evt), .row(row_q),
    .irq_row(irq_row), .irq_ack(irq_ack), .set_evt(set_evt),
    .frame_start(frame_start), .scan_row(scan_row), .irq(irq)
  );

  assign ram_rd    = fetch_go;
  assign ram_addr  = {act_page, row_q, byte_q};
  assign ser_clk   = shift_evt;
  assign ser_data  = shift_evt & sh_out;
  assign row_latch = latch_evt;

endmodule

// File: rtl/dotscan_chk.sv
module dotscan_chk #(
  parameter int ROW_W  = 5,
  parameter int PAGE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              slot_en,
  input logic              ram_rd,
  input logic              ser_clk,
  input logic              ser_data,
  input logic              row_latch,
  input logic              frame_start,
  input logic [ROW_W-1:0]  scan_row,
  input logic [ROW_W-1:0]  row_q,
  input logic              irq,
  input logic              irq_ack,
  input logic              set_evt,
  input logic              frame_load,
  input logic [PAGE_W-1:0] act_page
);

  AST_RD_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    ram_rd |-> slot_en); // R2
  AST_SER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_clk |-> !ser_data); // R3
  AST_NO_BIT_IN_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    row_latch |-> !ser_clk); // R3
  AST_LATCH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    row_latch |=> !row_latch); // R4
  AST_LATCH_AFTER_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    row_latch |-> $past(ser_clk)); // R4
  AST_SCAN_ROW_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    row_latch |=> scan_row == $past(row_q)); // R5
  AST_FRAME_WITH_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> row_latch); // R6
  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_load |=> $stable(act_page)); // R7
  AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> irq); // R8
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_ack) |=> irq); // R8
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !set_evt) |=> !irq); // R9

endmodule

bind dotscan_top dotscan_chk #(.ROW_W(ROW_W), .PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .slot_en(slot_en), .ram_rd(ram_rd),
  .ser_clk(ser_clk), .ser_data(ser_data), .row_latch(row_latch),
  .frame_start(frame_start), .scan_row(scan_row), .row_q(row_q),
  .irq(irq), .irq_ack(irq_ack), .set_evt(set_evt),
  .frame_load(frame_load), .act_page(act_page)
);

// File: tb/test_dotscan_top.sv
module test_dotscan_top;
  import dotscan_pkg::*;

  localparam int COLS   = 128;
  localparam int ROWS   = 32;
  localparam int BYTE_W = 8;
  localparam int BPR    = COLS / BYTE_W;
  localparam int PERIOD = BPR * BYTE_W + 2 * BPR + 1;
  localparam int NFRAMES = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slot_en = 1'b1;
  logic [3:0]  page_sel = 4'd3;
  logic [4:0]  irq_row = 5'd5;
  logic        irq_ack = 1'b0;
  logic        ram_rd;
  logic [12:0] ram_addr;
  logic [7:0]  ram_rdata = 8'h00;
  logic        ser_clk, ser_data, row_latch, frame_start, irq;
  logic [4:0]  scan_row;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int latch_count = 0;
  int last_lat_cyc = 0;
  bit gate = 1'b0;
  bit stop_mon = 1'b0;
  bit pend = 1'b0;
  int pend_row = 0;
  logic bit_exp_q[$];
  int   row_exp_q[$];

  dotscan_top i_dotscan_top (
    .clk(clk), .rst_n(rst_n), .slot_en(slot_en), .page_sel(page_sel),
    .irq_row(irq_row), .irq_ack(irq_ack), .ram_rd(ram_rd),
    .ram_addr(ram_addr), .ram_rdata(ram_rdata), .ser_clk(ser_clk),
    .ser_data(ser_data), .row_latch(row_latch), .frame_start(frame_start),
    .scan_row(scan_row), .irq(irq)
  );

  always #4 clk = ~clk;

  function automatic logic [7:0] pat(logic [12:0] a);
    logic [12:0] m;
    m = a * 13'd29;
    return m[7:0] ^ a[12:5] ^ 8'h5A;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Driver: expected bit stream and latched rows for one frame of a page (R1, R3)
  task automatic push_frame(logic [3:0] pg);
    for (int r = 0; r < ROWS; r++) begin
      for (int b = 0; b < BPR; b++) begin
        logic [7:0] d;
        d = pat({pg, 5'(r), 4'(b)});
        for (int i = BYTE_W - 1; i >= 0; i--) bit_exp_q.push_back(d[i]);
      end
      row_exp_q.push_back(r);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk) if (ram_rd) ram_rdata <= pat(ram_addr);
  always @(negedge clk) slot_en <= gate ? (cyc % 3 == 0) : 1'b1;

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !stop_mon) begin
      if (pend) begin
        pend = 1'b0;
        chk(scan_row == 5'(pend_row), "R5 scan_row", scan_row, pend_row);
        if (pend_row == 5) chk(irq == 1'b1, "R8 irq on match", irq, 1);
        if (pend_row == 4 && latch_count == 5) chk(irq == 1'b0, "R8 no early irq", irq, 0);
      end
      if (ram_rd) chk(slot_en == 1'b1, "R2 read outside slot", slot_en, 1);
      if (ser_clk) begin
        if (bit_exp_q.size() == 0) chk(1'b0, "R3 extra bit", 1, 0);
        else begin
          logic e;
          e = bit_exp_q.pop_front();
          chk(ser_data == e, "R3 serial bit", ser_data, e);
        end
      end else begin
        chk(ser_data == 1'b0, "R3 data idle", ser_data, 0);
      end
      if (row_latch) begin
        int er;
        er = (row_exp_q.size() > 0) ? row_exp_q.pop_front() : -1;
        chk(frame_start == (er == 0), "R6 frame_start", frame_start, er == 0);
        chk(bit_exp_q.size() == (ROWS * NFRAMES - 1 - latch_count) * COLS,
            "R4 latch after 128th bit", bit_exp_q.size(),
            (ROWS * NFRAMES - 1 - latch_count) * COLS);
        if (latch_count >= 1 && latch_count <= ROWS - 1)
          chk(cyc - last_lat_cyc == PERIOD && PERIOD == int'(row_cycles(BPR, BYTE_W)),
              "R10 row period", cyc - last_lat_cyc, PERIOD);
        last_lat_cyc = cyc;
        pend = 1'b1;
        pend_row = er;
        latch_count++;
      end
    end
  end

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", cyc, 0);
    summary();
    $finish;
  end

  initial begin
    push_frame(4'd3);
    push_frame(4'd7);
    push_frame(4'd12);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!ser_clk && !ram_rd && !row_latch && !irq && scan_row == 5'd0,
          "R11 reset state", {ser_clk, ram_rd, row_latch, irq}, 0);
    end
    @(negedge clk) rst_n = 1'b1;
    // R7: change page mid-frame 0; frame 0 must stay on page 3
    wait (latch_count == 3);
    @(negedge clk) page_sel = 4'd7;
    // R9: acknowledge clears the flag
    wait (latch_count == 10);
    @(negedge clk) irq_ack = 1'b1;
    @(negedge clk) irq_ack = 1'b0;
    chk(irq == 1'b0, "R9 ack clears", irq, 0);
    // R7 again plus gapped slots for frame 2
    wait (latch_count == 34);
    @(negedge clk) begin
      page_sel = 4'd12;
      gate = 1'b1;
    end
    // R9: set wins over a simultaneous ack
    wait (latch_count == 68);
    @(negedge clk) irq_ack = 1'b1;
    wait (latch_count == 70);
    @(posedge clk);
    #1 irq_ack = 1'b0;
    @(negedge clk);
    chk(irq == 1'b1, "R9 set beats ack", irq, 1);
    wait (latch_count == ROWS * NFRAMES);
    @(negedge clk);
    @(negedge clk);
    stop_mon = 1'b1;
    chk(bit_exp_q.size() == 0 && row_exp_q.size() == 0, "R1 stream consumed",
        bit_exp_q.size() + row_exp_q.size(), 0);
    summary();
    $finish;
  end

endmodule